// File: doc/BRIEF.md
# Encoded-Select Function Unit

This block is the combinational function stage of a register-file datapath. Two n-bit operands, A and B, and a 4-bit select code enter, and one n-bit result comes out with four status flags. The unit has an adder with an operand selector, a bitwise logic stage, a single-place shifter that acts on B, and an output multiplexer. The select code drives all of these directly. The upper two bits of the code pick the group (arithmetic, logic or shift). The lower bits pick the operation within that group.

The arithmetic group computes A + Y + cin. Y is zero, B, the complement of B, or all ones. cin is the lowest select bit. This one adder therefore covers pass, increment, add, add-plus-one, subtract with and without the extra one, and decrement. The flags are updated on every code, so a control sequencer can branch on the sign, the zero test, the carry or the overflow of the result in the same cycle.

Top module: `fnu_top`

## Requirements
- R1: For codes 0000 to 0111 the result is, modulo 2^WIDTH: 0000 A, 0001 A+1, 0010 A+B, 0011 A+B+1, 0100 A+~B, 0101 A-B, 0110 A-1 and 0111 A.
- R2: For codes 0000 to 0111, flag_c equals bit WIDTH of the unsigned sum A + Y + cin. Y is 0 for 000x, B for 001x, ~B for 010x and all ones for 011x, and cin is code bit 0.
- R3: For codes 0000 to 0111, flag_v is 1 exactly when A and Y have the same most significant bit and the result's most significant bit differs from it.
- R4: For codes 1000 to 1011 the result is A AND B, A OR B, A XOR B and NOT A, in that order.
- R5: Code 1100 passes B to the result. Code 1101 shifts B right by one place and puts 0 in the top bit. Code 1110 shifts B left by one place and puts 0 in the bottom bit.
- R6: Code 1111 gives a result of all zeros.
- R7: For codes 1000 to 1111, flag_c and flag_v are both 0.
- R8: For every code, flag_n equals the result's top bit and flag_z is 1 exactly when every result bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fs_code | input | 4 | Function select code |
| opnd_a | input | WIDTH | Operand A |
| opnd_b | input | WIDTH | Operand B (also the shifter source) |
| result | output | WIDTH | Selected function output |
| flag_v | output | 1 | Signed overflow of the adder |
| flag_c | output | 1 | Adder carry-out |
| flag_n | output | 1 | Result sign bit |
| flag_z | output | 1 | Result is all zeros |

## Verification
The hardest case to reach from the ports is the overflow and carry behaviour at the sign boundaries. Here the effective addend is ~B or all ones rather than B itself. Examples are decrement of the most negative value, subtract of the most negative value from zero, and code 0111, which always carries and never overflows. Directed tasks place the operands at 0x00, 0x7F, 0x80 and 0xFF under each arithmetic code. A full sweep then crosses all sixteen codes with a grid of boundary and alternating-bit operands.

// File: rtl/fnu_pkg.sv
// Package: shared group decode for the function unit.
// Assumes a 4-bit select code whose upper two bits pick the group.
package fnu_pkg;

    typedef enum logic [1:0] {
        GRP_ARITH = 2'b00,
        GRP_LOGIC = 2'b01,
        GRP_SHIFT = 2'b10
    } fnu_group_e;

    localparam int FS_BITS = 4;

    // Map the top select bits onto the operation group.
    function automatic fnu_group_e fnu_group(input logic [FS_BITS-1:0] fs);
        if (!fs[3])
            return GRP_ARITH;
        else if (!fs[2])
            return GRP_LOGIC;
        else
            return GRP_SHIFT;
    endfunction

endpackage

// File: rtl/fnu_arith.sv
// Module: arithmetic circuit computing a + y + cin.
// y is one of four functions of b, chosen by ysel: 00 zero, 01 b, 10 ~b, 11 ones.
// Assumes WIDTH >= 2. Purely combinational.
module fnu_arith #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [1:0]       ysel,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             ovf
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] y_opnd;
    logic [WIDTH:0]   wide_sum;

    // Operand selector: form the second adder input from b.
    always_comb begin
        unique case (ysel)
            2'b00:   y_opnd = '0;
            2'b01:   y_opnd = b;
            2'b10:   y_opnd = ~b;
            default: y_opnd = '1;
        endcase
    end

    // Adder with carry-in; the extra bit holds the carry-out.
    always_comb begin
        wide_sum = {1'b0, a} + {1'b0, y_opnd} + {{WIDTH{1'b0}}, cin};
        sum      = wide_sum[MSB:0];
        cout     = wide_sum[WIDTH];
    end

    // Signed overflow: like-signed operands give a sum of the other sign.
    always_comb begin
        ovf = (a[MSB] == y_opnd[MSB]) && (sum[MSB] != a[MSB]);
    end

endmodule

// File: rtl/fnu_logic.sv
// Module: bitwise logic circuit.
// op selects 00 AND, 01 OR, 10 XOR, 11 NOT a. Combinational, one gate level per bit.
module fnu_logic #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [1:0]       op,
    output logic [WIDTH-1:0] out
);
    // Per-bit function select.
    always_comb begin
        unique case (op)
            2'b00:   out = a & b;
            2'b01:   out = a | b;
            2'b10:   out = a ^ b;
            default: out = ~a;
        endcase
    end

endmodule

// File: rtl/fnu_shift.sv
// Module: single-place shifter on b.
// op selects 00 pass, 01 right, 10 left, 11 all zeros.
// fill_hi enters the top bit on a right shift; fill_lo enters the bottom bit on a left shift.
module fnu_shift #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] b,
    input  logic [1:0]       op,
    input  logic             fill_hi,
    input  logic             fill_lo,
    output logic [WIDTH-1:0] out
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] from_left;   // bit i receives b[i+1]
    logic [WIDTH-1:0] from_right;  // bit i receives b[i-1]

    // Neighbour wiring, one 4-way mux per bit position.
    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_bit
            if (gi == MSB) begin : g_top
                assign from_left[gi] = fill_hi;
            end else begin : g_mid_l
                assign from_left[gi] = b[gi+1];
            end
            if (gi == 0) begin : g_bot
                assign from_right[gi] = fill_lo;
            end else begin : g_mid_r
                assign from_right[gi] = b[gi-1];
            end

            // Bit mux: choose pass, right neighbour, left neighbour or zero.
            always_comb begin
                unique case (op)
                    2'b00:   out[gi] = b[gi];
                    2'b01:   out[gi] = from_left[gi];
                    2'b10:   out[gi] = from_right[gi];
                    default: out[gi] = 1'b0;
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/fnu_top.sv
// Module: encoded-select function unit.
// One 4-bit code drives the adder operand select, the logic op, the shifter op
// and the output multiplexer. The status flags follow the selected result.
// Assumes the shifter serial inputs are tied low. Combinational, no state.
module fnu_top #(
    parameter int WIDTH = 8
) (
    input  logic [3:0]       fs_code,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    output logic [WIDTH-1:0] result,
    output logic             flag_v,
    output logic             flag_c,
    output logic             flag_n,
    output logic             flag_z
);
    import fnu_pkg::*;

    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] arith_out;
    logic [WIDTH-1:0] logic_out;
    logic [WIDTH-1:0] shift_out;
    logic             arith_cout;
    logic             arith_ovf;
    fnu_group_e       grp;

    fnu_arith #(.WIDTH(WIDTH)) u_arith (
        .a    (opnd_a),
        .b    (opnd_b),
        .ysel (fs_code[2:1]),
        .cin  (fs_code[0]),
        .sum  (arith_out),
        .cout (arith_cout),
        .ovf  (arith_ovf)
    );

    fnu_logic #(.WIDTH(WIDTH)) u_logic (
        .a   (opnd_a),
        .b   (opnd_b),
        .op  (fs_code[1:0]),
        .out (logic_out)
    );

    fnu_shift #(.WIDTH(WIDTH)) u_shift (
        .b       (opnd_b),
        .op      (fs_code[1:0]),
        .fill_hi (1'b0),
        .fill_lo (1'b0),
        .out     (shift_out)
    );

    // Group decode from the top select bits.
    always_comb begin
        grp = fnu_group(fs_code);
    end

    // Output multiplexer with carry and overflow qualified by group.
    always_comb begin
        unique case (grp)
            GRP_ARITH: begin
                result = arith_out;
                flag_c = arith_cout;
                flag_v = arith_ovf;
            end
            GRP_LOGIC: begin
                result = logic_out;
                flag_c = 1'b0;
                flag_v = 1'b0;
            end
            default: begin
                result = shift_out;
                flag_c = 1'b0;
                flag_v = 1'b0;
            end
        endcase
    end

    // Sign and zero detect on the final result.
    always_comb begin
        flag_n = result[MSB];
        flag_z = ~|result;
    end

endmodule

// File: rtl/fnu_top_chk.sv
// Module: checker for fnu_top, bound to every instance.
// Uses immediate assertions because the unit has no clock; it relates
// the select code and operands to the result and flag ports.
module fnu_top_chk #(
    parameter int WIDTH = 8
) (
    input logic [3:0]       fs_code,
    input logic [WIDTH-1:0] opnd_a,
    input logic [WIDTH-1:0] opnd_b,
    input logic [WIDTH-1:0] result,
    input logic             flag_v,
    input logic             flag_c,
    input logic             flag_n,
    input logic             flag_z
);
    // Port-level properties, evaluated whenever an input or output moves.
    always_comb begin
        if (fs_code == 4'b0000)
            assert_pass_a_R1: assert (result == opnd_a && !flag_c && !flag_v);
        if (fs_code == 4'b0111)
            assert_a_carry_R2: assert (result == opnd_a && flag_c && !flag_v);
        if (fs_code == 4'b1100)
            assert_pass_b_R5: assert (result == opnd_b);
        if (fs_code == 4'b1111)
            assert_unused_zero_R6: assert (result == '0 && flag_z);
        if (fs_code[3])
            assert_no_overflow_R7: assert (!flag_v && !flag_c);
        if (flag_v)
            assert_ovf_arith_R3: assert (!fs_code[3]);
        assert_sign_R8: assert (flag_n == result[WIDTH-1]);
        assert_zero_R8: assert (flag_z == (result == '0));
    end
endmodule

bind fnu_top fnu_top_chk #(.WIDTH(WIDTH)) u_fnu_top_chk (
    .fs_code (fs_code),
    .opnd_a  (opnd_a),
    .opnd_b  (opnd_b),
    .result  (result),
    .flag_v  (flag_v),
    .flag_c  (flag_c),
    .flag_n  (flag_n),
    .flag_z  (flag_z)
);

// File: tb/fnu_top_bench.sv
// Bench: directed tasks against fnu_top, expected values computed from the requirements.
module fnu_top_bench;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic [3:0]   fs;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [W-1:0] f;
    logic         v, c, n, z;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    fnu_top #(.WIDTH(W)) u_fnu_top (
        .fs_code (fs), .opnd_a (a), .opnd_b (b),
        .result (f), .flag_v (v), .flag_c (c), .flag_n (n), .flag_z (z)
    );

    // Expected outputs taken from the requirement text.
    task automatic expect_for(input logic [3:0] code, input logic [W-1:0] xa,
                              input logic [W-1:0] xb, output logic [W-1:0] ef,
                              output logic ev, output logic ec);
        int ua, uy, sa, sy, cin, tot, st;
        ua = int'(xa); sa = int'($signed(xa));
        ev = 1'b0; ec = 1'b0;
        if (!code[3]) begin
            case (code[2:1])
                2'b00:   uy = 0;
                2'b01:   uy = int'(xb);
                2'b10:   uy = 255 - int'(xb);
                default: uy = 255;
            endcase
            sy  = (uy >= 128) ? uy - 256 : uy;
            cin = int'(code[0]);
            tot = ua + uy + cin;
            st  = sa + sy + cin;
            ef  = tot[W-1:0];
            ec  = (tot >= 256);
            ev  = (st > 127) || (st < -128);
        end else begin
            case (code[2:0])
                3'b000:  ef = xa & xb;
                3'b001:  ef = xa | xb;
                3'b010:  ef = xa ^ xb;
                3'b011:  ef = ~xa;
                3'b100:  ef = xb;
                3'b101:  ef = {1'b0, xb[W-1:1]};
                3'b110:  ef = {xb[W-2:0], 1'b0};
                default: ef = '0;
            endcase
        end
    endtask

    // Apply one vector, sample mid-cycle, compare every output.
    task automatic apply_check(input logic [3:0] code, input logic [W-1:0] xa,
                               input logic [W-1:0] xb, input string tag);
        logic [W-1:0] ef;
        logic ev, ec, en, ez;
        @(negedge clk);
        fs = code; a = xa; b = xb;
        #2;
        expect_for(code, xa, xb, ef, ev, ec);
        en = ef[W-1];
        ez = (ef == '0);
        checks++;
        if (f !== ef || v !== ev || c !== ec || n !== en || z !== ez) begin
            fails++;
            $display("FAIL %s fs=%b a=%h b=%h: got f=%h v%b c%b n%b z%b, expected f=%h v%b c%b n%b z%b",
                     tag, code, xa, xb, f, v, c, n, z, ef, ev, ec, en, ez);
        end
    endtask

    // Initial all-zero inputs: pass of zero, zero flag set.
    task automatic t_idle;
        apply_check(4'b0000, 8'h00, 8'h00, "R1 R8 idle");
    endtask

    task automatic t_arith;
        apply_check(4'b0000, 8'h5A, 8'hFF, "R1 pass A");
        apply_check(4'b0001, 8'h41, 8'h00, "R1 inc");
        apply_check(4'b0010, 8'h47, 8'h20, "R1 add");
        apply_check(4'b0011, 8'h10, 8'h20, "R1 add+1");
        apply_check(4'b0100, 8'h30, 8'h10, "R1 add notB");
        apply_check(4'b0101, 8'h30, 8'h10, "R1 sub");
        apply_check(4'b0110, 8'h30, 8'h00, "R1 dec");
        apply_check(4'b0111, 8'h30, 8'h99, "R1 pass A alt");
    endtask

    task automatic t_carry;
        apply_check(4'b0001, 8'hFF, 8'h00, "R2 inc wrap");
        apply_check(4'b0010, 8'h80, 8'h80, "R2 add carry");
        apply_check(4'b0101, 8'h10, 8'h10, "R2 sub equal");
        apply_check(4'b0101, 8'h10, 8'h11, "R2 sub borrow");
        apply_check(4'b0110, 8'h00, 8'h00, "R2 dec zero");
        apply_check(4'b0111, 8'h00, 8'h00, "R2 code7 carry");
    endtask

    task automatic t_overflow;
        apply_check(4'b0001, 8'h7F, 8'h00, "R3 inc max");
        apply_check(4'b0010, 8'h7F, 8'h01, "R3 add pos");
        apply_check(4'b0010, 8'h80, 8'hFF, "R3 add neg");
        apply_check(4'b0101, 8'h00, 8'h80, "R3 sub min");
        apply_check(4'b0110, 8'h80, 8'h00, "R3 dec min");
        apply_check(4'b0111, 8'h80, 8'h00, "R3 code7 none");
    endtask

    task automatic t_logic;
        apply_check(4'b1000, 8'hF0, 8'h3C, "R4 and");
        apply_check(4'b1001, 8'hF0, 8'h3C, "R4 or");
        apply_check(4'b1010, 8'hF0, 8'h3C, "R4 xor");
        apply_check(4'b1011, 8'hF0, 8'h3C, "R4 not");
    endtask

    task automatic t_shift;
        apply_check(4'b1100, 8'h12, 8'hA5, "R5 pass B");
        apply_check(4'b1101, 8'h00, 8'h81, "R5 shr fill0");
        apply_check(4'b1110, 8'h00, 8'h81, "R5 shl fill0");
        apply_check(4'b1101, 8'hFF, 8'h01, "R5 shr to zero");
    endtask

    task automatic t_unused;
        apply_check(4'b1111, 8'hFF, 8'hFF, "R6 unused");
        apply_check(4'b1111, 8'h80, 8'h7F, "R6 unused alt");
    endtask

    task automatic t_flags;
        apply_check(4'b1110, 8'hFF, 8'hC0, "R7 shl carries no C");
        apply_check(4'b1001, 8'h80, 8'h80, "R7 or no V");
        apply_check(4'b1010, 8'hAA, 8'hAA, "R8 xor zero");
        apply_check(4'b1011, 8'h00, 8'h00, "R8 not neg");
    endtask

    // Cross every code with a grid of boundary operands.
    task automatic t_sweep;
        logic [W-1:0] pats [8] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF, 8'h55, 8'hAA, 8'h3C};
        for (int k = 0; k < 16; k++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    apply_check(4'(k), pats[i], pats[j],
                                k < 8 ? "R1 R2 R3 R8 sweep" :
                                k < 12 ? "R4 R7 R8 sweep" : "R5 R6 R7 R8 sweep");
    endtask

    initial begin
        fs = '0; a = '0; b = '0;
        t_idle();
        t_arith();
        t_carry();
        t_overflow();
        t_logic();
        t_shift();
        t_unused();
        t_flags();
        t_sweep();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // Watchdog: an overrun counts as a failed check.
    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule